// File: doc/BRIEF.md
# SD card data-word FIFO with programmable request thresholds

This block buffers 32-bit data words between a host register port and the word side of an SD data-line shifter. One storage array serves both directions. Which direction is active follows from a 4-bit data-path state code that the card side loads. In a read state the card side pushes words and the host drains them through the data register. In a write state the host fills the FIFO and the card side takes the words.

A debug register packs four things into one word: the data-path state, the current fill level, and two 5-bit thresholds. The thresholds set when a data-request flag is raised. The host can use that flag to move words in bursts rather than polling the fill level. Overflow, underflow and port collisions set a sticky FIFO error flag, and software clears it by writing 1. A force bit in the debug register returns the data path to data idle and empties the FIFO in the same cycle.

Registers sit at `hst_addr` 0 (data), 1 (debug) and 2 (status). Reads return their value on `hst_rdata` in the cycle after `hst_rd`. Address 3 reads as zero.

Top module: `sd_word_fifo`

## Requirements
- R1: After reset the fill level is 0, the state code is 0 (identify), the error flag and the request flag are 0, and both thresholds are 4, so the debug register reads 0x00010800.
- R2: The FIFO holds DEPTH (16) words and delivers them in the order they were written, on whichever side pops them. The fill level changes by at most one per cycle, except on a flush.
- R3: The fill level is visible on `level_o` and in debug bits 8:4, and it never exceeds DEPTH.
- R4: A debug write loads the write threshold from bits 13:9 and the read threshold from bits 18:14. Both read back at those positions.
- R5: The state code sits in debug bits 3:0 and on `lane_state_o`. It is loaded from `crd_state` when `crd_state_ld` is 1. The codes are 0 identify, 1 data idle, 2 read data, 3 write data, 4 read wait, 5 read CRC, 6 write CRC, 7 write wait 1, 10 write start 1, 11 write start 2 and 13 write wait 2.
- R6: In the read states (2, 4, 5) the request flag is 1 exactly when the fill level is at or above the read threshold.
- R7: In the write states (3, 6, 7, 10, 11, 13) the request flag is 1 exactly when DEPTH minus the fill level is at or above the write threshold. In every other state it is 0.
- R8: A pop from an empty FIFO or a push into a full FIFO, from either side, sets the error flag and leaves the contents and the level unchanged. An empty host data read returns 0.
- R9: Status bit 0 is the request flag and status bit 3 is the error flag. Writing 1 to status bit 3 clears the error, unless a new error occurs in the same cycle.
- R10: A debug write with bit 19 set forces the state to 1 (data idle) and empties the FIFO, so the level reads 0 in the next cycle. Bit 19 reads back as 0, and card-side activity in that cycle is discarded without an error.
- R11: When a host data access and a card-side access of the same kind (two pushes or two pops) happen in the same cycle, the host access is served and the card access is dropped with the error flag set. A dropped card pop does not raise `crd_rvalid`.
- R12: A host data read returns the popped word on `hst_rdata` one cycle after `hst_rd`. A card pop raises `crd_rvalid` with the word on `crd_rdata` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_wr | input | 1 | Host register write strobe |
| hst_rd | input | 1 | Host register read strobe |
| hst_addr | input | 2 | Register select: 0 data, 1 debug, 2 status |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid the cycle after hst_rd |
| crd_push | input | 1 | Card side pushes a received word |
| crd_wdata | input | 32 | Word pushed by the card side |
| crd_pop | input | 1 | Card side takes a word to transmit |
| crd_rdata | output | 32 | Word taken by the card side |
| crd_rvalid | output | 1 | crd_rdata holds a freshly popped word |
| crd_state_ld | input | 1 | Load the data-path state code |
| crd_state | input | 4 | State code to load |
| lane_state_o | output | 4 | Current data-path state code |
| level_o | output | 5 | Current fill level |
| dreq_o | output | 1 | Data-request flag |
| ferr_o | output | 1 | Sticky FIFO error flag |

## Verification
A wrong pointer or level in this block shows within one cycle on `level_o`. It also surfaces as a wrong word at the next pop, at most DEPTH cycles later. A stale threshold or state register shows on `dreq_o` as soon as the level crosses the threshold. The reference model tracks the queue, the level, the state and the error flag on every clock. It therefore catches a misordered word or a missed error on the cycle it first becomes visible. Long random runs mix both directions, threshold rewrites, collisions and rare flushes.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  // register select codes on the host port
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_DBG  = 2'd1;
  localparam logic [1:0] A_STS  = 2'd2;

  // debug word field positions
  localparam int LVL_LO   = 4;
  localparam int WTH_LO   = 9;
  localparam int RTH_LO   = 14;
  localparam int FORCE_BT = 19;
  localparam int FLD_W    = 5;

  // status word bit positions
  localparam int STS_DREQ = 0;
  localparam int STS_ERR  = 3;

  // data-path state codes
  localparam logic [3:0] ST_IDENT   = 4'd0;
  localparam logic [3:0] ST_IDLE    = 4'd1;
  localparam logic [3:0] ST_RDAT    = 4'd2;
  localparam logic [3:0] ST_WDAT    = 4'd3;
  localparam logic [3:0] ST_RWAIT   = 4'd4;
  localparam logic [3:0] ST_RCRC    = 4'd5;
  localparam logic [3:0] ST_WCRC    = 4'd6;
  localparam logic [3:0] ST_WWAIT1  = 4'd7;
  localparam logic [3:0] ST_WSTART1 = 4'd10;
  localparam logic [3:0] ST_WSTART2 = 4'd11;
  localparam logic [3:0] ST_WWAIT2  = 4'd13;

  function automatic logic is_rd_state(input logic [3:0] s);
    return (s == ST_RDAT) || (s == ST_RWAIT) || (s == ST_RCRC);
  endfunction

  function automatic logic is_wr_state(input logic [3:0] s);
    return (s == ST_WDAT) || (s == ST_WCRC) || (s == ST_WWAIT1) ||
           (s == ST_WSTART1) || (s == ST_WSTART2) || (s == ST_WWAIT2);
  endfunction
endpackage

// File: rtl/sdw_mem.sv
module sdw_mem #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] mem [DEPTH];

  // simple dual-port array with registered read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/sdw_ptrs.sv
module sdw_ptrs #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             ovf,
  output logic             unf,
  output logic [AW-1:0]    wptr,
  output logic [AW-1:0]    rptr,
  output logic [LVL_W-1:0] level
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [AW-1:0]    LAST     = AW'(DEPTH - 1);

  // full and empty are judged on the level before this cycle
  assign push_ok = push_req && !flush && (level != FULL_LVL);
  assign pop_ok  = pop_req  && !flush && (level != '0);
  assign ovf     = push_req && !flush && !push_ok;
  assign unf     = pop_req  && !flush && !pop_ok;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/sdw_csr.sv
module sdw_csr
  import sdw_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int RTHR_RST = 4,
  parameter int WTHR_RST = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dbg_we,
  input  logic             sts_we,
  input  logic             force_idle,
  input  logic [31:0]      wdata,
  input  logic             state_ld,
  input  logic [3:0]       state_in,
  input  logic [LVL_W-1:0] level,
  input  logic             err_evt,
  input  logic             rd_en,
  input  logic [1:0]       rd_addr,
  output logic [3:0]       state,
  output logic             ferr,
  output logic             dreq,
  output logic [31:0]      rd_q
);
  logic [FLD_W-1:0] rthr, wthr;
  logic [FLD_W-1:0] lvl_f;
  logic [31:0]      dbg_word, sts_word;

  assign lvl_f = FLD_W'(level);

  // request flag from registered state only
  always_comb begin
    dreq = 1'b0;
    if (is_rd_state(state))
      dreq = int'(level) >= int'(rthr);
    else if (is_wr_state(state))
      dreq = (DEPTH - int'(level)) >= int'(wthr);
  end

  always_comb begin
    dbg_word = '0;
    dbg_word[3:0]                 = state;
    dbg_word[LVL_LO +: FLD_W]     = lvl_f;
    dbg_word[WTH_LO +: FLD_W]     = wthr;
    dbg_word[RTH_LO +: FLD_W]     = rthr;
    sts_word = '0;
    sts_word[STS_DREQ] = dreq;
    sts_word[STS_ERR]  = ferr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rthr  <= FLD_W'(RTHR_RST);
      wthr  <= FLD_W'(WTHR_RST);
      state <= ST_IDENT;
      ferr  <= 1'b0;
      rd_q  <= '0;
    end else begin
      if (dbg_we) begin
        wthr <= wdata[WTH_LO +: FLD_W];
        rthr <= wdata[RTH_LO +: FLD_W];
      end
      if (force_idle)    state <= ST_IDLE;
      else if (state_ld) state <= state_in;
      if (err_evt)                      ferr <= 1'b1;
      else if (sts_we && wdata[STS_ERR]) ferr <= 1'b0;
      if (rd_en) begin
        case (rd_addr)
          A_DBG:   rd_q <= dbg_word;
          A_STS:   rd_q <= sts_word;
          default: rd_q <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sd_word_fifo.sv
module sd_word_fifo
  import sdw_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  parameter int RTHR_RST = 4,
  parameter int WTHR_RST = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hst_wr,
  input  logic             hst_rd,
  input  logic [1:0]       hst_addr,
  input  logic [WIDTH-1:0] hst_wdata,
  output logic [WIDTH-1:0] hst_rdata,
  input  logic             crd_push,
  input  logic [WIDTH-1:0] crd_wdata,
  input  logic             crd_pop,
  output logic [WIDTH-1:0] crd_rdata,
  output logic             crd_rvalid,
  input  logic             crd_state_ld,
  input  logic [3:0]       crd_state,
  output logic [3:0]       lane_state_o,
  output logic [LVL_W-1:0] level_o,
  output logic             dreq_o,
  output logic             ferr_o
);
  logic h_dwr, h_drd, dbg_we, sts_we, force_idle;
  logic push_ok, pop_ok, ovf, unf, err_evt, sel_mem;
  logic [AW-1:0]    wptr, rptr;
  logic [WIDTH-1:0] push_data, mem_q;
  logic [31:0]      csr_q, wd32;

  assign wd32       = 32'(hst_wdata);
  assign h_dwr      = hst_wr && (hst_addr == A_DATA);
  assign h_drd      = hst_rd && (hst_addr == A_DATA);
  assign dbg_we     = hst_wr && (hst_addr == A_DBG);
  assign sts_we     = hst_wr && (hst_addr == A_STS);
  assign force_idle = dbg_we && wd32[FORCE_BT];
  assign push_data  = h_dwr ? hst_wdata : crd_wdata;

  // a card access that loses to the host counts as an error
  assign err_evt = ovf || unf ||
                   (!force_idle && ((h_dwr && crd_push) || (h_drd && crd_pop)));

  sdw_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .flush(force_idle),
    .push_req(h_dwr || crd_push), .pop_req(h_drd || crd_pop),
    .push_ok(push_ok), .pop_ok(pop_ok), .ovf(ovf), .unf(unf),
    .wptr(wptr), .rptr(rptr), .level(level_o)
  );

  sdw_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(push_ok), .waddr(wptr), .wdata(push_data),
    .re(pop_ok), .raddr(rptr), .q(mem_q)
  );

  sdw_csr #(.DEPTH(DEPTH), .RTHR_RST(RTHR_RST), .WTHR_RST(WTHR_RST)) u_csr (
    .clk(clk), .rst(rst), .dbg_we(dbg_we), .sts_we(sts_we),
    .force_idle(force_idle), .wdata(wd32),
    .state_ld(crd_state_ld), .state_in(crd_state), .level(level_o),
    .err_evt(err_evt), .rd_en(hst_rd), .rd_addr(hst_addr),
    .state(lane_state_o), .ferr(ferr_o), .dreq(dreq_o), .rd_q(csr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_mem    <= 1'b0;
      crd_rvalid <= 1'b0;
    end else begin
      if (hst_rd) sel_mem <= h_drd && pop_ok;
      crd_rvalid <= pop_ok && !h_drd;
    end
  end

  assign hst_rdata = sel_mem ? mem_q : WIDTH'(csr_q);
  assign crd_rdata = mem_q;
endmodule

// File: rtl/sdw_chk.sv
module sdw_chk #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             hst_wr,
  input logic             hst_rd,
  input logic [1:0]       hst_addr,
  input logic [WIDTH-1:0] hst_wdata,
  input logic             crd_push,
  input logic             crd_pop,
  input logic             crd_rvalid,
  input logic [3:0]       lane_state_o,
  input logic [LVL_W-1:0] level_o,
  input logic             ferr_o
);
  logic frc;
  assign frc = hst_wr && (hst_addr == 2'd1) && hst_wdata[19];

  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(level_o) <= DEPTH);

  // R2
  level_step_chk: assert property (@(posedge clk) disable iff (rst)
    !frc |=> (int'(level_o) <= int'($past(level_o)) + 1) &&
             (int'(level_o) + 1 >= int'($past(level_o))));

  // R10
  force_flush_chk: assert property (@(posedge clk) disable iff (rst)
    frc |=> (level_o == '0) && (lane_state_o == 4'd1));

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (hst_rd && hst_addr == 2'd0 && level_o == '0) |=> ferr_o);

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (hst_wr && hst_addr == 2'd2 && hst_wdata[3] && !crd_push && !crd_pop) |=> !ferr_o);

  // R11
  pop_collide_chk: assert property (@(posedge clk) disable iff (rst)
    (hst_rd && hst_addr == 2'd0 && crd_pop) |=> (!crd_rvalid && ferr_o));
endmodule

bind sd_word_fifo sdw_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_sdw_chk (
  .clk(clk), .rst(rst), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
  .hst_wdata(hst_wdata), .crd_push(crd_push), .crd_pop(crd_pop),
  .crd_rvalid(crd_rvalid), .lane_state_o(lane_state_o), .level_o(level_o),
  .ferr_o(ferr_o)
);

// File: tb/tb_sd_word_fifo.sv
module tb_sd_word_fifo;
  localparam int DEPTH = 16;

  logic        clk = 0, rst = 1;
  logic        hst_wr = 0, hst_rd = 0, crd_push = 0, crd_pop = 0, crd_state_ld = 0;
  logic [1:0]  hst_addr = 0;
  logic [31:0] hst_wdata = 0, crd_wdata = 0;
  logic [3:0]  crd_state = 0;
  logic [31:0] hst_rdata, crd_rdata;
  logic        crd_rvalid, dreq_o, ferr_o;
  logic [3:0]  lane_state_o;
  logic [4:0]  level_o;

  int checks = 0, errors = 0;

  // reference model
  logic [31:0] mq[$];
  int          m_rthr, m_wthr;
  logic [3:0]  m_st;
  logic        m_err, m_rv, m_hvalid;
  logic [31:0] m_crd, m_hrd;
  string       m_htag;

  sd_word_fifo dut (.*);

  always #10 clk = ~clk;

  function automatic logic rd_st(logic [3:0] s);
    return s == 2 || s == 4 || s == 5;
  endfunction
  function automatic logic wr_st(logic [3:0] s);
    return s == 3 || s == 6 || s == 7 || s == 10 || s == 11 || s == 13;
  endfunction
  function automatic logic m_dreq();
    if (rd_st(m_st)) return mq.size() >= m_rthr;
    if (wr_st(m_st)) return (DEPTH - mq.size()) >= m_wthr;
    return 1'b0;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    int pre = mq.size();
    logic frc, hdw, hdr, popok, pushok, evt;
    logic [31:0] front, dbgw, stsw;
    frc = hst_wr && hst_addr == 1 && hst_wdata[19];
    hdw = hst_wr && hst_addr == 0;
    hdr = hst_rd && hst_addr == 0;
    dbgw = {13'b0, 5'(m_rthr), 5'(m_wthr), 5'(pre), m_st};
    stsw = {28'b0, m_err, 2'b0, m_dreq()};
    evt = 0; front = 0; popok = 0; m_rv = 0;
    if (frc) mq.delete();
    else begin
      popok = (hdr || crd_pop) && pre > 0;
      if ((hdr || crd_pop) && !popok) evt = 1;
      if (hdr && crd_pop) evt = 1;
      if (popok) front = mq.pop_front();
      pushok = (hdw || crd_push) && pre < DEPTH;
      if ((hdw || crd_push) && !pushok) evt = 1;
      if (hdw && crd_push) evt = 1;
      if (pushok) mq.push_back(hdw ? hst_wdata : crd_wdata);
      m_rv = popok && !hdr;
      if (m_rv) m_crd = front;
    end
    m_hvalid = hst_rd;
    if (hst_rd) begin
      case (hst_addr)
        0: begin m_hrd = popok ? front : 0; m_htag = "R12"; end
        1: begin m_hrd = dbgw; m_htag = "R4"; end
        2: begin m_hrd = stsw; m_htag = "R9"; end
        default: begin m_hrd = 0; m_htag = "R9"; end
      endcase
    end
    if (hst_wr && hst_addr == 1) begin
      m_wthr = hst_wdata[13:9];
      m_rthr = hst_wdata[18:14];
    end
    if (evt) m_err = 1;
    else if (hst_wr && hst_addr == 2 && hst_wdata[3]) m_err = 0;
    if (frc) m_st = 1;
    else if (crd_state_ld) m_st = crd_state;
  endtask

  task automatic model_reset();
    mq.delete(); m_rthr = 4; m_wthr = 4; m_st = 0; m_err = 0; m_rv = 0; m_hvalid = 0;
  endtask

  task automatic step();
    @(posedge clk);
    if (rst) model_reset(); else model_step();
    @(negedge clk);
    if (!rst) begin
      chk(level_o == 5'(mq.size()), "R3 level", 32'(level_o), 32'(mq.size()));
      chk(lane_state_o == m_st, "R5 state", 32'(lane_state_o), 32'(m_st));
      chk(dreq_o == m_dreq(), rd_st(m_st) ? "R6 dreq" : "R7 dreq", 32'(dreq_o), 32'(m_dreq()));
      chk(ferr_o == m_err, "R8 error", 32'(ferr_o), 32'(m_err));
      chk(crd_rvalid == m_rv, "R11 rvalid", 32'(crd_rvalid), 32'(m_rv));
      if (m_rv) chk(crd_rdata == m_crd, "R2 card word", crd_rdata, m_crd);
      if (m_hvalid) chk(hst_rdata == m_hrd, m_htag, hst_rdata, m_hrd);
    end
    hst_wr = 0; hst_rd = 0; crd_push = 0; crd_pop = 0; crd_state_ld = 0;
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [31:0] d);
    hst_wr = 1; hst_addr = a; hst_wdata = d; step();
  endtask
  task automatic hread(input logic [1:0] a);
    hst_rd = 1; hst_addr = a; step();
  endtask
  task automatic load_state(input logic [3:0] s);
    crd_state_ld = 1; crd_state = s; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) step();
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(level_o == 0 && lane_state_o == 0, "R1 level/state", {level_o, lane_state_o}, 0);
    chk(!ferr_o && !dreq_o, "R1 flags", {ferr_o, dreq_o}, 0);
    hread(1);
    chk(hst_rdata == 32'h0001_0800, "R1 debug word", hst_rdata, 32'h0001_0800);

    // R5/R7 write direction: host fills, then overflows (R8)
    load_state(4'd3);
    for (int i = 0; i < DEPTH; i++) hwrite(0, 32'hA000_0000 + i);
    chk(level_o == 16, "R2 full level", 32'(level_o), 16);
    hwrite(0, 32'hDEAD_BEEF);
    chk(ferr_o == 1 && level_o == 16, "R8 overflow", {ferr_o, level_o}, {1'b1, 5'd16});
    for (int i = 0; i < DEPTH; i++) begin crd_pop = 1; step(); end
    crd_pop = 1; step();
    // R9 clear error
    hwrite(2, 32'h8);
    chk(ferr_o == 0, "R9 clear", 32'(ferr_o), 0);

    // read direction with thresholds (R4, R6)
    load_state(4'd2);
    hwrite(1, (32'd8 << 14) | (32'd2 << 9));
    hread(1);
    for (int i = 0; i < 10; i++) begin crd_push = 1; crd_wdata = 32'h5500_0000 + i; step(); end
    hread(2);
    for (int i = 0; i < 10; i++) hread(0);
    hread(0);
    chk(ferr_o == 1, "R8 empty read", 32'(ferr_o), 1);
    hwrite(2, 32'h8);

    // R11 collisions
    crd_push = 1; crd_wdata = 32'h1111; hst_wr = 1; hst_addr = 0; hst_wdata = 32'h2222; step();
    crd_pop = 1; hst_rd = 1; hst_addr = 0; step();
    chk(hst_rdata == 32'h2222, "R11 host wins", hst_rdata, 32'h2222);

    // R10 force idle and flush
    for (int i = 0; i < 5; i++) begin crd_push = 1; crd_wdata = i; step(); end
    hwrite(1, (32'd1 << 19) | (32'd4 << 14) | (32'd4 << 9));
    chk(level_o == 0 && lane_state_o == 1, "R10 flush", {level_o, lane_state_o}, {5'd0, 4'd1});

    // mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      if (r < 3) begin crd_state_ld = 1; crd_state = 4'($urandom); end
      if (r >= 3 && r < 25) begin hst_wr = 1; hst_addr = 0; hst_wdata = $urandom; end
      else if (r < 45) begin hst_rd = 1; hst_addr = 2'($urandom_range(0, 3)); end
      else if (r < 48) begin hst_wr = 1; hst_addr = 1; hst_wdata = $urandom & 32'h0007_FFFF; end
      else if (r == 48) begin hst_wr = 1; hst_addr = 1; hst_wdata = $urandom | 32'h0008_0000; end
      else if (r < 52) begin hst_wr = 1; hst_addr = 2; hst_wdata = $urandom; end
      if ($urandom_range(0, 3) == 0) begin crd_push = 1; crd_wdata = $urandom; end
      if ($urandom_range(0, 3) == 0) crd_pop = 1;
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule